// File: doc/BRIEF.md
# Bypassable 16-Bit Integer Clock Divider

This block derives a slower clock from a parent clock by an integer ratio held in one 32-bit control word. The upper half of the word is the ratio. The two lowest bits form an enable pair. When both enable bits are set and the ratio is 2 or more, a counter running on the parent clock produces an output whose period is the ratio in parent cycles. The output is high for the first half of each period, rounded down.

A ratio of 0 or 1 with both enable bits set routes the parent clock straight to the output. Any other enable pattern holds the output low. This includes the all-zero control word. A ratio written while the divider runs takes effect only when the current output period ends, so no shortened period appears. Each time division starts after the block was off or in pass-through, the counter begins at zero with a full high phase.

Top module: `clk_int_divider`

## Requirements
- R1: The control word stores the ratio in bits 31:16 and the enable pair in bits 1:0; bits 15:2 read as zero and ignore written values; after reset the word reads 0.
- R2: With enable pair 2'b11 and a ratio N of 2 or more, the output period is exactly N parent cycles.
- R3: Within each period the high phase lasts floor(N/2) parent cycles and the low phase lasts N - floor(N/2), so odd ratios have a high phase one cycle shorter than the low phase.
- R4: With enable pair 2'b11 and a ratio of 0 or 1, the output equals the parent clock.
- R5: With any enable pair other than 2'b11 (including the all-zero word), the output is low from the first parent edge after the write onward, whatever the ratio.
- R6: On entering division mode the counter starts at zero, so the first period begins with a complete high phase of floor(N/2) cycles.
- R7: A new ratio of 2 or more written while dividing is applied from the next period boundary; the period in progress finishes with the old ratio.
- R8: The largest ratio, 0xFFFF, gives a period of 65535 parent cycles with 32767 high and 32768 low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Writes wr_data into the control word at the rising edge |
| wr_data | input | 32 | Control word write value |
| rd_data | output | 32 | Control word read value |
| clk_out | output | 1 | Divided, passed-through or held-low output clock |

## Verification
The divider is run with even ratios (2, 4, 6), odd ratios (3, 5, 7) and the maximum ratio. Even and odd ratios separate a wrong period length from a wrong split between the phases. A ratio changed in the middle of a period tells an immediate reload apart from a reload at the boundary. Disable in the middle of a period followed by re-enable shows whether the counter restarts from zero. The pass-through ratios 0 and 1, the partial enable pairs 2'b01, 2'b10 and 2'b00 with a valid ratio, and the all-zero word separate the three output modes.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_PASS = 2'd1,
    MODE_DIV  = 2'd2
  } cdiv_mode_e;

  localparam logic [1:0] ENABLE_BOTH = 2'b11;

  // Length of the high phase for a ratio n: the lower half, rounded down.
  function automatic logic [31:0] high_len(input logic [31:0] n);
    return n >> 1;
  endfunction

  // Operating mode from the enable pair and the ratio.
  function automatic cdiv_mode_e pick_mode(input logic [1:0] en, input logic [31:0] ratio);
    if (en != ENABLE_BOTH) return MODE_OFF;
    if (ratio < 32'd2)     return MODE_PASS;
    return MODE_DIV;
  endfunction

endpackage

// File: rtl/cdiv_regs.sv
module cdiv_regs #(
  parameter int DIV_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2*DIV_W-1:0] wr_data,
  output logic [DIV_W-1:0]   ratio_o,
  output logic [1:0]         en_pair_o,
  output logic [2*DIV_W-1:0] rd_data
);
  localparam int REG_W = 2 * DIV_W;
  localparam int GAP_W = REG_W - DIV_W - 2;

  logic [DIV_W-1:0] ratio_q;
  logic [1:0]       en_q;
  logic             unused_gap;

  assign unused_gap = ^wr_data[DIV_W-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= '0;
      en_q    <= '0;
    end else if (wr_en) begin
      ratio_q <= wr_data[REG_W-1 -: DIV_W];
      en_q    <= wr_data[1:0];
    end
  end

  assign ratio_o   = ratio_q;
  assign en_pair_o = en_q;
  assign rd_data   = {ratio_q, {GAP_W{1'b0}}, en_q};

  AST_REG_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == {$past(wr_data[REG_W-1 -: DIV_W]), {GAP_W{1'b0}}, $past(wr_data[1:0])}); // R1

endmodule

// File: rtl/cdiv_decode.sv
module cdiv_decode #(
  parameter int DIV_W = 16
) (
  input  logic [DIV_W-1:0] ratio_i,
  input  logic [1:0]       en_pair_i,
  output logic             is_div_o,
  output logic             is_pass_o
);
  import cdiv_pkg::*;

  cdiv_mode_e mode;

  always_comb begin
    mode      = pick_mode(en_pair_i, 32'(ratio_i));
    is_div_o  = (mode == MODE_DIV);
    is_pass_o = (mode == MODE_PASS);
  end

endmodule

// File: rtl/cdiv_counter.sv
module cdiv_counter #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_req_i,
  input  logic [DIV_W-1:0] ratio_i,
  output logic             div_clk_o
);
  import cdiv_pkg::*;

  logic [DIV_W-1:0] cnt_q, act_q, n_cnt, n_act;
  logic             run_q, q_q;
  logic             wrap_ev, start_ev;

  // Named events for the checks below.
  assign wrap_ev  = run_q && (cnt_q == act_q - DIV_W'(1));
  assign start_ev = run_req_i && !run_q;

  always_comb begin
    n_cnt = wrap_ev ? '0 : cnt_q + DIV_W'(1);
    n_act = wrap_ev ? ratio_i : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      act_q <= '0;
      q_q   <= 1'b0;
    end else if (!run_req_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      act_q <= '0;
      q_q   <= 1'b0;
    end else if (start_ev) begin
      run_q <= 1'b1;
      cnt_q <= '0;
      act_q <= ratio_i;
      q_q   <= 32'd0 < high_len(32'(ratio_i));
    end else begin
      cnt_q <= n_cnt;
      act_q <= n_act;
      q_q   <= 32'(n_cnt) < high_len(32'(n_act));
    end
  end

  assign div_clk_o = q_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < act_q) && (act_q >= DIV_W'(2))); // R2

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run_req_i |=> !div_clk_o); // R5

  AST_START_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> div_clk_o && (cnt_q == '0)); // R6

  AST_HOLD_MID_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && run_req_i && !wrap_ev) |=> $stable(act_q)); // R7

endmodule

// File: rtl/clk_int_divider.sv
module clk_int_divider #(
  parameter int DIV_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [2*DIV_W-1:0]   wr_data,
  output logic [2*DIV_W-1:0]   rd_data,
  output logic                 clk_out
);
  logic [DIV_W-1:0] ratio;
  logic [1:0]       en_pair;
  logic             is_div, is_pass, div_clk;

  cdiv_regs #(.DIV_W(DIV_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .ratio_o   (ratio),
    .en_pair_o (en_pair),
    .rd_data   (rd_data)
  );

  cdiv_decode #(.DIV_W(DIV_W)) u_decode (
    .ratio_i   (ratio),
    .en_pair_i (en_pair),
    .is_div_o  (is_div),
    .is_pass_o (is_pass)
  );

  cdiv_counter #(.DIV_W(DIV_W)) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_req_i (is_div),
    .ratio_i   (ratio),
    .div_clk_o (div_clk)
  );

  // Pass-through selects the parent clock itself; otherwise the counter output.
  assign clk_out = is_pass ? clk : div_clk;

  AST_PASS_COUNTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    is_pass |=> !div_clk); // R4

endmodule

// File: tb/clk_int_divider_test.sv
module clk_int_divider_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        clk_out;
  logic        mon_on = 1'b0;

  int checks = 0;
  int fails  = 0;
  int exp_hi[$];
  int exp_lo[$];
  string exp_tag[$];

  always #5 clk = ~clk;

  clk_int_divider uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .clk_out(clk_out)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] word(input int ratio, input logic [1:0] en);
    return {ratio[15:0], 14'd0, en};
  endfunction

  // Driver side of the scoreboard: expected phases from the ratio.
  task automatic expect_periods(input int n, input int count, input string tag);
    for (int i = 0; i < count; i++) begin
      exp_hi.push_back(n / 2);
      exp_lo.push_back(n - n / 2);
      exp_tag.push_back(tag);
    end
  endtask

  task automatic drain();
    while (exp_hi.size() != 0) @(posedge clk);
  endtask

  task automatic check_low(input int cycles, input string tag);
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #2; chk(tag, clk_out, 0);
      @(negedge clk); #2; chk(tag, clk_out, 0);
    end
  endtask

  task automatic check_follow(input int cycles, input string tag);
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #2; chk(tag, clk_out, 1);
      @(negedge clk); #2; chk(tag, clk_out, 0);
    end
  endtask

  task automatic run_ratio(input int n, input int count, input string tag);
    expect_periods(n, count, tag);
    mon_on = 1'b1;
    wr(word(n, 2'b11));
    drain();
    mon_on = 1'b0;
    wr(32'd0);
    @(posedge clk);
  endtask

  // Monitor: measures high and low run lengths between rising edges.
  initial begin : monitor
    logic prev, cur;
    bit   started;
    int   hi, lo;
    prev = 1'b0; started = 1'b0; hi = 0; lo = 0;
    forever begin
      @(negedge clk);
      cur = clk_out;
      if (!mon_on) begin
        started = 1'b0; hi = 0; lo = 0; prev = cur;
      end else begin
        if (cur && !prev) begin
          if (started && exp_hi.size() > 0) begin
            string t;
            int eh, el;
            t  = exp_tag.pop_front();
            eh = exp_hi.pop_front();
            el = exp_lo.pop_front();
            chk({t, " high phase"}, hi, eh);
            chk({t, " low phase"}, lo, el);
          end
          started = 1'b1; hi = 1; lo = 0;
        end else if (cur) hi++;
        else lo++;
        prev = cur;
      end
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset word", rd_data, 0);
    chk("R5 reset output", clk_out, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: middle bits ignored, fields kept.
    wr(32'hFFFF_FFFC);
    #1; chk("R1 readback mid bits", rd_data, 32'hFFFF_0000);
    wr(32'h1234_5679);
    #1; chk("R1 readback fields", rd_data, 32'h1234_0001);
    check_low(2, "R5 partial enable 01");
    wr(word(4, 2'b10));
    check_low(3, "R5 partial enable 10");
    wr(word(4, 2'b00));
    check_low(3, "R5 enable pair 00");
    wr(32'd0);

    // R2/R3: even and odd ratios.
    run_ratio(2, 3, "R2 ratio 2");
    run_ratio(4, 3, "R2 ratio 4");
    run_ratio(3, 3, "R3 ratio 3");
    run_ratio(5, 3, "R3 ratio 5");
    run_ratio(7, 2, "R3 ratio 7");

    // R7: change ratio in mid period.
    expect_periods(4, 2, "R7 old ratio");
    expect_periods(6, 2, "R7 new ratio");
    mon_on = 1'b1;
    wr(word(4, 2'b11));
    repeat (6) @(posedge clk);
    wr(word(6, 2'b11));
    drain();
    mon_on = 1'b0;

    // R5: disable mid period holds low.
    wr(32'd0);
    check_low(4, "R5 zero word");

    // R6: stop mid period, restart gives full first high phase.
    wr(word(6, 2'b11));
    repeat (4) @(posedge clk);
    wr(32'd0);
    @(posedge clk);
    wr(word(6, 2'b11));
    for (int j = 1; j <= 6; j++) begin
      @(posedge clk); #2;
      chk("R6 restart phase", clk_out, (j <= 3) ? 1 : 0);
    end
    wr(32'd0);
    @(posedge clk);

    // R4: pass-through for ratios 0 and 1.
    wr(word(1, 2'b11));
    check_follow(4, "R4 ratio 1");
    wr(word(0, 2'b11));
    check_follow(4, "R4 ratio 0");
    wr(word(1, 2'b01));
    check_low(3, "R5 ratio 1 partial enable");

    // R4 then R6: leaving pass-through starts a fresh period.
    wr(word(0, 2'b11));
    @(posedge clk);
    run_ratio(6, 2, "R6 from pass-through");

    // R8: largest ratio.
    run_ratio(65535, 1, "R8 max ratio");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule